// File: doc/BRIEF.md
# Parallel EEPROM Host Access Controller

This block is a clocked master that runs the strobes of a 2048 x 8 byte-wide EEPROM for a user port using a valid/ready handshake. A request carries a read/write flag, an 11-bit byte address and, for writes, one data byte. The controller keeps the address steady on the memory pins for the whole transaction. It produces the chip-select, output-enable and write-strobe sequences from parameters for setup, pulse and hold lengths. It drives the shared data bus only while it is writing.

A write does not finish after a fixed wait. Once the write strobe returns high, the controller reads the same location again and again. It stops when the device gives back the written byte, or when a poll budget runs out. That budget is derived from a 10 ms worst-case internal programming time and the clock frequency. The transaction ends with a one-clock done pulse. For a write that hit the limit, an error flag rises with that pulse. The returned byte is the value read, or for a write the last value polled.

Top module: `eeprom_host_ctrl`

## Requirements
- R1: While reset is held, `req_ready` is 1, `ee_ce_n`, `ee_oe_n` and `ee_we_n` are 1, `ee_dq_oe` is 0, and `rsp_done` and `rsp_error` are 0.
- R2: A read request (`req_write`=0) pulls `ee_ce_n` and `ee_oe_n` low at `req_addr`. It ends with `rsp_done`=1, `rsp_error`=0, and `rsp_rdata` equal to the byte the device presented at that address.
- R3: `ee_we_n` goes low only while `ee_ce_n` is 0 and `ee_oe_n` is 1. Each low pulse lasts exactly `PULSE_CYC` clocks. During the pulse, `ee_addr` and `ee_dq_out` do not change and `ee_dq_oe` is 1.
- R4: `ee_dq_oe` is 0 in every cycle where `ee_oe_n` is 0. It is also 0 in the cycle before each falling edge of `ee_oe_n`.
- R5: After a write pulse, the controller reads the written address repeatedly. When the device returns the written byte, it ends with `rsp_done`=1, `rsp_error`=0 and `rsp_rdata` equal to that byte.
- R6: Each low pulse of `ee_oe_n` lasts exactly the read wait, ceil(`READ_NS` x `CLK_MHZ` / 1000) clocks. Back-to-back poll reads are separated by at least one clock with `ee_oe_n` high.
- R7: If the written byte has not been read back within `WRITE_MAX_US` x `CLK_MHZ` clocks of polling, the controller raises `rsp_error` in the same cycle as `rsp_done`, with `rsp_rdata` equal to the last polled byte. `req_ready` is 1 in the cycle after that pulse. `rsp_error` is never 1 without `rsp_done`.
- R8: `req_ready` falls in the clock after a request is accepted. It stays 0 up to and including the single-cycle `rsp_done` pulse, and returns to 1 in the next clock.
- R9: A request presented while `req_ready` is 0 is ignored. It produces no done pulse and no write to the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| rsp_done | output | 1 | One-cycle end-of-transaction pulse |
| rsp_error | output | 1 | Write poll timed out (only with done) |
| rsp_rdata | output | 8 | Byte read, or last polled byte |
| ee_addr | output | 11 | Memory address pins |
| ee_ce_n | output | 1 | Memory chip enable, active low |
| ee_oe_n | output | 1 | Memory output enable, active low |
| ee_we_n | output | 1 | Memory write strobe, active low |
| ee_dq_out | output | 8 | Data driven toward the memory |
| ee_dq_oe | output | 1 | Host drive enable for the data bus |
| ee_dq_in | input | 8 | Data returned by the memory |

## Verification
If the sequencer is in the wrong state, it shows at the pins within the same cycle, because every strobe is decoded directly from the state register. A wrong state can appear as a bus drive overlapping an output-enable low, a write strobe outside chip enable, or a strobe of the wrong width. A wrong phase count moves a strobe edge by at least one clock, and pulse-width counting catches that on the next rising edge. A faulty poll comparison or watchdog appears only at the end of the transaction. It shows as a done pulse that comes too early, never comes, or carries the wrong error flag. The scoreboard catches it when that pulse is compared.

// File: rtl/eeprom_ctrl_pkg.sv
package eeprom_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_END,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_PL_SETUP,
    ST_PL_WAIT,
    ST_PL_GAP,
    ST_DONE
  } seq_state_t;

  // Access time in ns turned into whole clocks, rounded up, at least one.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  // Microsecond budget turned into clocks.
  function automatic int unsigned us_to_cycles(int unsigned us, int unsigned mhz);
    return us * mhz;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] target,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == target - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (!last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ee_poll_watchdog.sv
module ee_poll_watchdog #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int W = $clog2(LIMIT + 1) + 1;
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  assign expired = (cnt_q >= LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ee_seq_fsm.sv
module ee_seq_fsm
  import eeprom_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 20,
  parameter int HOLD_CYC  = 2,
  parameter int READ_CYC  = 30,
  parameter int TMR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              phase_last,
  input  logic              poll_expired,
  input  logic [DATA_W-1:0] dq_in,
  output seq_state_t        state,
  output logic              phase_restart,
  output logic [TMR_W-1:0]  phase_target,
  output logic              poll_run,
  output logic              accept_evt,
  output logic              sample_evt,
  output logic              match_evt,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ee_addr,
  output logic              ee_ce_n,
  output logic              ee_oe_n,
  output logic              ee_we_n,
  output logic [DATA_W-1:0] ee_dq_out,
  output logic              ee_dq_oe
);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              match_q;
  logic              err_q;

  assign state = state_q;

  always_comb begin
    unique case (state_q)
      ST_RD_SETUP, ST_WR_SETUP, ST_PL_SETUP: phase_target = TMR_W'(SETUP_CYC);
      ST_WR_PULSE:                           phase_target = TMR_W'(PULSE_CYC);
      ST_WR_HOLD:                            phase_target = TMR_W'(HOLD_CYC);
      ST_RD_WAIT, ST_PL_WAIT:                phase_target = TMR_W'(READ_CYC);
      default:                               phase_target = TMR_W'(1);
    endcase
  end

  assign accept_evt = (state_q == ST_IDLE) && req_valid;
  assign sample_evt = ((state_q == ST_RD_WAIT) || (state_q == ST_PL_WAIT)) && phase_last;
  assign match_evt  = (state_q == ST_PL_WAIT) && phase_last && (dq_in == wdata_q);
  assign poll_run   = (state_q == ST_PL_SETUP) || (state_q == ST_PL_WAIT) ||
                      (state_q == ST_PL_GAP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
      ST_RD_SETUP: if (phase_last) state_d = ST_RD_WAIT;
      ST_RD_WAIT:  if (phase_last) state_d = ST_RD_END;
      ST_RD_END:   if (phase_last) state_d = ST_DONE;
      ST_WR_SETUP: if (phase_last) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (phase_last) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  if (phase_last) state_d = ST_PL_SETUP;
      ST_PL_SETUP: if (phase_last) state_d = ST_PL_WAIT;
      ST_PL_WAIT:  if (phase_last) state_d = ST_PL_GAP;
      ST_PL_GAP: begin
        if (phase_last) begin
          if (match_q || poll_expired) state_d = ST_DONE;
          else                         state_d = ST_PL_SETUP;
        end
      end
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign phase_restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      match_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_evt) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        match_q <= 1'b0;
        err_q   <= 1'b0;
      end
      if (sample_evt) begin
        rdata_q <= dq_in;
        match_q <= match_evt;
      end
      if ((state_q == ST_PL_GAP) && phase_last && !match_q && poll_expired) begin
        err_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ee_ce_n  = 1'b1;
    ee_oe_n  = 1'b1;
    ee_we_n  = 1'b1;
    ee_dq_oe = 1'b0;
    unique case (state_q)
      ST_RD_SETUP, ST_PL_SETUP: ee_ce_n = 1'b0;
      ST_RD_WAIT, ST_PL_WAIT: begin
        ee_ce_n = 1'b0;
        ee_oe_n = 1'b0;
      end
      ST_WR_SETUP, ST_WR_HOLD: begin
        ee_ce_n  = 1'b0;
        ee_dq_oe = 1'b1;
      end
      ST_WR_PULSE: begin
        ee_ce_n  = 1'b0;
        ee_we_n  = 1'b0;
        ee_dq_oe = 1'b1;
      end
      default: ;
    endcase
  end

  assign ee_addr   = addr_q;
  assign ee_dq_out = wdata_q;
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_done  = (state_q == ST_DONE);
  assign rsp_error = (state_q == ST_DONE) && err_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/eeprom_host_ctrl.sv
module eeprom_host_ctrl
  import eeprom_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int CLK_MHZ      = 200,
  parameter int READ_NS      = 150,
  parameter int WRITE_MAX_US = 10000,
  parameter int SETUP_CYC    = 2,
  parameter int PULSE_CYC    = 20,
  parameter int HOLD_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ee_addr,
  output logic              ee_ce_n,
  output logic              ee_oe_n,
  output logic              ee_we_n,
  output logic [DATA_W-1:0] ee_dq_out,
  output logic              ee_dq_oe,
  input  logic [DATA_W-1:0] ee_dq_in
);

  localparam int unsigned READ_CYC   = ns_to_cycles(READ_NS, CLK_MHZ);
  localparam int unsigned POLL_LIMIT = us_to_cycles(WRITE_MAX_US, CLK_MHZ);
  localparam int unsigned LONGEST    = max3(max3(SETUP_CYC, PULSE_CYC, HOLD_CYC), READ_CYC, 1);
  localparam int TMR_W               = $clog2(LONGEST + 1) + 1;

  seq_state_t       state;
  logic             phase_restart;
  logic [TMR_W-1:0] phase_target;
  logic             phase_last;
  logic             poll_run;
  logic             poll_expired;
  logic             accept_evt;
  logic             sample_evt;
  logic             match_evt;

  ee_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .READ_CYC(int'(READ_CYC)), .TMR_W(TMR_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .phase_last(phase_last), .poll_expired(poll_expired), .dq_in(ee_dq_in),
    .state(state), .phase_restart(phase_restart), .phase_target(phase_target),
    .poll_run(poll_run), .accept_evt(accept_evt), .sample_evt(sample_evt), .match_evt(match_evt),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .ee_addr(ee_addr), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n),
    .ee_dq_out(ee_dq_out), .ee_dq_oe(ee_dq_oe)
  );

  ee_phase_timer #(.CNT_W(TMR_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .restart(phase_restart),
    .target(phase_target), .last(phase_last)
  );

  ee_poll_watchdog #(.LIMIT(POLL_LIMIT)) wdog_i (
    .clk(clk), .rst_n(rst_n), .run(poll_run), .expired(poll_expired)
  );

endmodule

// File: rtl/eeprom_host_ctrl_chk.sv
module eeprom_host_ctrl_chk #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 20,
  parameter int READ_CYC  = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              rsp_error,
  input logic [ADDR_W-1:0] ee_addr,
  input logic              ee_ce_n,
  input logic              ee_oe_n,
  input logic              ee_we_n,
  input logic [DATA_W-1:0] ee_dq_out,
  input logic              ee_dq_oe,
  input logic              accept_evt,
  input logic              match_evt,
  input logic              poll_expired
);

  logic [15:0] we_low_cnt;
  logic [15:0] oe_low_cnt;
  logic        matched_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt   <= '0;
      oe_low_cnt   <= '0;
      matched_seen <= 1'b0;
    end else begin
      we_low_cnt <= ee_we_n ? 16'd0 : we_low_cnt + 16'd1;
      oe_low_cnt <= ee_oe_n ? 16'd0 : oe_low_cnt + 16'd1;
      if (accept_evt)     matched_seen <= 1'b0;
      else if (match_evt) matched_seen <= 1'b1;
    end
  end

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_we_n |-> (!ee_ce_n && ee_oe_n)); // R3
  AST_WE_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_we_n && !$past(ee_we_n)) |-> ($stable(ee_addr) && $stable(ee_dq_out) && ee_dq_oe)); // R3
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_we_n) |-> (we_low_cnt == 16'(PULSE_CYC))); // R3
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_oe_n |-> !ee_dq_oe); // R4
  AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_oe_n) |-> !$past(ee_dq_oe)); // R4
  AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_oe_n) |-> (oe_low_cnt == 16'(READ_CYC))); // R6
  AST_OE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_oe_n) |=> ee_oe_n); // R6
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> rsp_done); // R7
  AST_ERR_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> (poll_expired && !matched_seen)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready)); // R8
  AST_READY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && req_ready)); // R8
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready); // R8

endmodule

bind eeprom_host_ctrl eeprom_host_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC), .READ_CYC(int'(READ_CYC))
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done), .rsp_error(rsp_error),
  .ee_addr(ee_addr), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n),
  .ee_dq_out(ee_dq_out), .ee_dq_oe(ee_dq_oe), .accept_evt(accept_evt),
  .match_evt(match_evt), .poll_expired(poll_expired)
);

// File: tb/eeprom_host_ctrl_tb_top.sv
module eeprom_host_ctrl_tb_top;

  localparam int PULSE  = 3;
  localparam int RD_WIN = 30;     // 150 ns at 5 ns per clock
  localparam int BUSY   = 200;    // device programming time in clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done, rsp_error;
  logic [7:0]  rsp_rdata;
  logic [10:0] ee_addr;
  logic        ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe;
  logic [7:0]  ee_dq_out, ee_dq_in;

  always #2.5 clk = ~clk;

  eeprom_host_ctrl #(
    .CLK_MHZ(200), .READ_NS(150), .WRITE_MAX_US(20),
    .SETUP_CYC(2), .PULSE_CYC(PULSE), .HOLD_CYC(1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .ee_addr(ee_addr), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n),
    .ee_dq_out(ee_dq_out), .ee_dq_oe(ee_dq_oe), .ee_dq_in(ee_dq_in)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  function automatic logic [7:0] init_byte(logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'b10110};
  endfunction

  logic [7:0] mem [2048];
  logic [7:0] pend_byte = '0;
  int         busy_left = 0;
  bit         stuck = 1'b0;
  logic       prev_we_n = 1'b1;
  int         write_pulses = 0;

  initial for (int i = 0; i < 2048; i++) mem[i] = init_byte(11'(i));

  always_comb begin
    if (!ee_ce_n && !ee_oe_n)
      ee_dq_in = (busy_left > 0) ? {~pend_byte[7], pend_byte[6:0]} : mem[ee_addr];
    else
      ee_dq_in = 8'h00;
  end

  always @(posedge clk) begin
    prev_we_n <= ee_we_n;
    if (!prev_we_n && ee_we_n && !ee_ce_n) begin
      mem[ee_addr] <= ee_dq_out;
      pend_byte    <= ee_dq_out;
      busy_left    <= BUSY;
      write_pulses <= write_pulses + 1;
    end else if (busy_left > 0 && !stuck) begin
      busy_left <= busy_left - 1;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] rd; bit err; string req; } exp_t;
  exp_t exp_q[$];
  int   done_count = 0;
  bit   chk_ready_next = 1'b0;
  string last_req = "";

  always @(negedge clk) begin
    if (chk_ready_next) begin
      check(req_ready == 1'b1, last_req, "ready after done", int'(req_ready), 1);
      chk_ready_next = 1'b0;
    end
    if (rst_n && rsp_done) begin
      done_count++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_rdata == e.rd, e.req, "rdata", int'(rsp_rdata), int'(e.rd));
        check(rsp_error == e.err, e.req, "error flag", int'(rsp_error), int'(e.err));
        check(req_ready == 1'b0, "R8", "ready during done", int'(req_ready), 0);
        last_req = "R8";
        chk_ready_next = 1'b1;
      end
    end
  end

  // ---------------- pin monitor ----------------
  int we_len = 0, oe_len = 0, oe_pulses = 0;
  int fight_viol = 0, we_viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ee_oe_n && ee_dq_oe) fight_viol++;                 // R4
      if (!ee_we_n && (ee_ce_n || !ee_oe_n)) we_viol++;       // R3
      if (!ee_we_n) we_len++;
      else if (we_len != 0) begin
        check(we_len == PULSE, "R3", "write strobe width", we_len, PULSE);
        we_len = 0;
      end
      if (!ee_oe_n) oe_len++;
      else if (oe_len != 0) begin
        check(oe_len == RD_WIN, "R6", "read strobe width", oe_len, RD_WIN);
        oe_len = 0;
        oe_pulses++;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue(bit wr, logic [10:0] a, logic [7:0] d, logic [7:0] erd, bit eerr, string req);
    exp_t e;
    e.rd = erd; e.err = eerr; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    check(req_ready == 1'b0, "R8", "ready after accept", int'(req_ready), 0);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int p0, w0, d0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    check({ee_ce_n, ee_oe_n, ee_we_n} == 3'b111, "R1", "strobes in reset",
          int'({ee_ce_n, ee_oe_n, ee_we_n}), 7);
    check(ee_dq_oe == 1'b0, "R1", "bus drive in reset", int'(ee_dq_oe), 0);
    check({rsp_done, rsp_error} == 2'b00, "R1", "done/error in reset",
          int'({rsp_done, rsp_error}), 0);
    rst_n = 1'b1;

    // R2: plain reads
    issue(1'b0, 11'h005, 8'h00, init_byte(11'h005), 1'b0, "R2"); wait_idle();
    issue(1'b0, 11'h7FF, 8'h00, init_byte(11'h7FF), 1'b0, "R2"); wait_idle();

    // R5: write completes by polling
    p0 = oe_pulses;
    issue(1'b1, 11'h123, 8'h5A, 8'h5A, 1'b0, "R5"); wait_idle();
    check(oe_pulses - p0 >= 2, "R5", "poll reads issued", oe_pulses - p0, 2);
    issue(1'b0, 11'h123, 8'h00, 8'h5A, 1'b0, "R5"); wait_idle();
    issue(1'b1, 11'h000, 8'hA5, 8'hA5, 1'b0, "R5"); wait_idle();
    issue(1'b0, 11'h000, 8'h00, 8'hA5, 1'b0, "R2"); wait_idle();

    // R9: request held while busy must be ignored
    w0 = write_pulses; d0 = done_count;
    issue(1'b0, 11'h200, 8'h00, init_byte(11'h200), 1'b0, "R9");
    req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h201; req_wdata = 8'hC3;
    repeat (12) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    check(done_count - d0 == 1, "R9", "done pulses", done_count - d0, 1);
    check(write_pulses == w0, "R9", "device writes", write_pulses - w0, 0);
    issue(1'b0, 11'h201, 8'h00, init_byte(11'h201), 1'b0, "R9"); wait_idle();

    // R7: device never finishes -> timeout with error
    stuck = 1'b1;
    issue(1'b1, 11'h300, 8'h3C, 8'hBC, 1'b1, "R7"); wait_idle();
    stuck = 1'b0;
    repeat (BUSY + 20) @(negedge clk);
    issue(1'b0, 11'h300, 8'h00, 8'h3C, 1'b0, "R7"); wait_idle();

    repeat (3) @(negedge clk);
    check(fight_viol == 0, "R4", "bus drive with OE low", fight_viol, 0);
    check(we_viol == 0, "R3", "write strobe outside CE/OE rule", we_viol, 0);
    check(exp_q.size() == 0, "R8", "pending responses", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule